// File: doc/BRIEF.md
# Multi-Range Resistance Slope Sequencer

This block is the digital controller that sits behind an analog resistance-to-ramp front end. The front end converts an unknown resistance into a current. A scaled copy of that current charges an on-chip capacitor, and an ADC digitises the resulting voltage ramp. The controller does four things:

- It selects one of three decade ranges through a one-hot code. That code sets the mirror ratio and the reference level in the analog section.
- It holds the integrator in reset between ramps.
- It runs the ADC clock only while the capacitor is charging.
- It reduces the ADC codes of each ramp to a slope figure.

A fixed offset in the analog chain shifts every code of a ramp by the same amount. For that reason only differences between successive codes are used. Codes close to either rail fall in the amplifier's nonlinear region and are discarded. One measurement is the mean of 128 ramps, formed by summing the ramp values and shifting right by seven bits.

Software pulses `start` with a range code. The block then runs 128 reset-plus-integrate cycles on its own and pulses `res_valid` with the averaged slope and the range it used. The resistance is proportional to (mirror ratio term × reference level) divided by (slope × capacitance). That arithmetic is done outside this block.

Top module: `rmeas_seq`

## Requirements
- R1: After reset: `int_rst`=1, `adc_clk`=0, `busy`=0, `res_valid`=0, `range_err`=0 and `range_oh`=3'b001.
- R2: A `start` pulse while idle with `range_sel` equal to 3'b001 (low decade), 3'b010 (middle decade) or 3'b100 (high decade) has three effects on the next cycle: `range_oh` takes that code, `busy` goes high and `range_err` clears.
- R3: A `start` while idle with any other `range_sel` value sets `range_err` on the next cycle. The block stays idle, `busy` stays low and `int_rst` stays high.
- R4: Each ramp is RST_CYCLES (4) cycles with `int_rst` high followed by RAMP_CYCLES (40) cycles with `int_rst` low. One measurement has exactly 2^RAMPS_LOG2 (128) ramps.
- R5: `adc_clk` is low in every cycle where `int_rst` is high. While `int_rst` is low, `adc_clk` is high in the first integration cycle and inverts every cycle after that.
- R6: A sample (`smp_valid`=1) counts only when it arrives in a cycle with `int_rst` low and its code lies within RAIL_MARGIN..(2^CODE_W−1−RAIL_MARGIN), which is 32..991. Every other sample is ignored.
- R7: The value of a ramp is the sum, over its counted samples, of each counted code minus the previous counted code of the same ramp. The first counted sample of a ramp contributes nothing.
- R8: One cycle after the last integration cycle of ramp 128, three things happen in that cycle: `res_valid` pulses for one cycle, `busy` is low, and `res_slope` equals floor(sum of the 128 ramp values / 128) as a signed number.
- R9: A `start` while `busy` is high is ignored. `range_oh` and the result range are unchanged.
- R10: `res_slope` and `res_range` hold their values between results. `res_range` equals the range code used for that measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a new measurement |
| range_sel | input | 3 | Requested one-hot decade range |
| smp_valid | input | 1 | ADC code valid this cycle |
| smp_code | input | 10 | ADC output code |
| range_oh | output | 3 | Active range driven to the analog front end |
| int_rst | output | 1 | Integrator reset phase (high = capacitor shorted) |
| adc_clk | output | 1 | Gated conversion clock, toggling only while integrating |
| busy | output | 1 | A measurement is in progress |
| range_err | output | 1 | Last start request carried an illegal range code |
| res_valid | output | 1 | One-cycle result strobe |
| res_slope | output | 17 | Averaged signed slope of the ramps |
| res_range | output | 3 | Range the result was taken in |

## Verification
The assertions check the following on every cycle:
- the conversion clock is low during the reset phase and toggles while integrating;
- the phase counter stays within bounds;
- an illegal start leaves the block idle;
- a start while busy cannot alter the range;
- the per-ramp sum is empty outside integration;
- the accumulator changes only at ramp ends;
- the result strobe is a single cycle right after integration.

Other properties can only be shown by the bench's scenarios, because they need a model of the whole measurement. These are the arithmetic value of the average, the rejection of samples near the rails, the ramp and reset lengths, and the count of 128 ramps. The scenarios cover rising, descending, flat, rail-crossing and fully out-of-window ramps.

// File: rtl/rmeas_pkg.sv
package rmeas_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RST   = 2'd1,
    ST_INTEG = 2'd2
  } rmeas_state_t;

  // legal range codes are exactly one bit set
  function automatic logic range_legal(input logic [2:0] code);
    return (code == 3'b001) || (code == 3'b010) || (code == 3'b100);
  endfunction

  // code usable for slope: not within margin of either rail
  function automatic logic in_window(input int code, input int margin, input int maxc);
    return (code >= margin) && (code <= (maxc - margin));
  endfunction

endpackage

// File: rtl/rmeas_ctrl.sv
module rmeas_ctrl
  import rmeas_pkg::*;
#(
  parameter int RST_CYCLES  = 4,
  parameter int RAMP_CYCLES = 40,
  parameter int RAMPS_LOG2  = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] range_sel,
  output logic [2:0] range_q,
  output logic       range_err,
  output logic       busy,
  output logic       integ,
  output logic       integ_nx,
  output logic       ramp_done,
  output logic       last_ramp,
  output logic       clr
);

  localparam int PH_MAX = (RST_CYCLES > RAMP_CYCLES) ? RST_CYCLES : RAMP_CYCLES;
  localparam int PH_W   = (PH_MAX > 1) ? $clog2(PH_MAX) : 1;

  rmeas_state_t          state, state_nx;
  logic [PH_W-1:0]       ph;
  logic [RAMPS_LOG2-1:0] ridx;
  logic                  legal;
  logic                  rst_end;

  assign legal     = range_legal(range_sel);
  assign integ     = (state == ST_INTEG);
  assign busy      = (state != ST_IDLE);
  assign rst_end   = (state == ST_RST) && (ph == PH_W'(RST_CYCLES - 1));
  assign ramp_done = integ && (ph == PH_W'(RAMP_CYCLES - 1));
  assign last_ramp = ramp_done && (ridx == {RAMPS_LOG2{1'b1}});
  assign clr       = (state == ST_IDLE) && start && legal;
  assign integ_nx  = (state_nx == ST_INTEG);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (clr) state_nx = ST_RST;
      ST_RST:   if (rst_end) state_nx = ST_INTEG;
      ST_INTEG: if (ramp_done) state_nx = last_ramp ? ST_IDLE : ST_RST;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ph        <= '0;
      ridx      <= '0;
      range_q   <= 3'b001;
      range_err <= 1'b0;
    end else begin
      state <= state_nx;
      unique case (state)
        ST_IDLE: begin
          ph   <= '0;
          ridx <= '0;
          if (start) begin
            if (legal) begin
              range_q   <= range_sel;
              range_err <= 1'b0;
            end else begin
              range_err <= 1'b1;
            end
          end
        end
        ST_RST: ph <= rst_end ? '0 : ph + 1'b1;
        ST_INTEG: begin
          if (ramp_done) begin
            ph   <= '0;
            ridx <= ridx + 1'b1;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        default: ph <= '0;
      endcase
    end
  end

  // R3
  illegal_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start && !legal) |=> (range_err && state == ST_IDLE));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(range_q));

  // R4
  phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    integ |-> (ph < PH_W'(RAMP_CYCLES)));

  // R2
  active_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $onehot(range_q));

endmodule

// File: rtl/rmeas_clkgate.sv
module rmeas_clkgate (
  input  logic clk,
  input  logic rst_n,
  input  logic integ,
  input  logic integ_nx,
  output logic adc_clk
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) adc_clk <= 1'b0;
    else        adc_clk <= integ_nx ? ~adc_clk : 1'b0;
  end

  // R5
  gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !integ |-> !adc_clk);

  // R5
  gate_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (integ && $past(integ)) |-> (adc_clk != $past(adc_clk)));

endmodule

// File: rtl/rmeas_slope.sv
module rmeas_slope
  import rmeas_pkg::*;
#(
  parameter int CODE_W      = 10,
  parameter int RAIL_MARGIN = 32,
  parameter int RS_W        = 17
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   integ,
  input  logic                   ramp_done,
  input  logic                   smp_valid,
  input  logic [CODE_W-1:0]      smp_code,
  output logic signed [RS_W-1:0] ramp_total
);

  localparam int MAX_CODE = (1 << CODE_W) - 1;

  logic [CODE_W-1:0]      prev_q;
  logic                   have_prev;
  logic signed [RS_W-1:0] ramp_sum;
  logic                   win_ok;
  logic                   take;
  logic                   take_diff;
  logic signed [CODE_W:0] diff;
  logic signed [RS_W-1:0] diff_ext;

  assign win_ok    = in_window(int'(smp_code), RAIL_MARGIN, MAX_CODE);
  assign take      = integ && smp_valid && win_ok;
  assign take_diff = take && have_prev;
  assign diff      = $signed({1'b0, smp_code}) - $signed({1'b0, prev_q});
  assign diff_ext  = {{(RS_W-CODE_W-1){diff[CODE_W]}}, diff};
  assign ramp_total = ramp_sum + (take_diff ? diff_ext : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      have_prev <= 1'b0;
      ramp_sum  <= '0;
    end else begin
      if (take) prev_q <= smp_code;
      if (!integ || ramp_done) begin
        have_prev <= 1'b0;
        ramp_sum  <= '0;
      end else begin
        ramp_sum <= ramp_total;
        if (take) have_prev <= 1'b1;
      end
    end
  end

  // R6
  idle_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !integ |-> (ramp_sum == '0 && !have_prev));

  // R6
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (integ && smp_valid && !win_ok && !ramp_done) |=> ($stable(prev_q) && $stable(ramp_sum)));

endmodule

// File: rtl/rmeas_avg.sv
module rmeas_avg #(
  parameter int RS_W       = 17,
  parameter int RAMPS_LOG2 = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   ramp_done,
  input  logic                   last_ramp,
  input  logic signed [RS_W-1:0] ramp_total,
  input  logic [2:0]             range_in,
  output logic                   res_valid,
  output logic signed [RS_W-1:0] res_slope,
  output logic [2:0]             res_range
);

  localparam int ACC_W = RS_W + RAMPS_LOG2;

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] sum_nx;

  assign sum_nx = acc + {{RAMPS_LOG2{ramp_total[RS_W-1]}}, ramp_total};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      res_valid <= 1'b0;
      res_slope <= '0;
      res_range <= 3'b000;
    end else begin
      res_valid <= 1'b0;
      if (clr) begin
        acc <= '0;
      end else if (ramp_done) begin
        if (last_ramp) begin
          acc       <= '0;
          res_slope <= sum_nx[ACC_W-1:RAMPS_LOG2];
          res_range <= range_in;
          res_valid <= 1'b1;
        end else begin
          acc <= sum_nx;
        end
      end
    end
  end

  // R8
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr || ramp_done) |=> $stable(acc));

  // R8
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R10
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_slope) && $stable(res_range)));

endmodule

// File: rtl/rmeas_seq.sv
module rmeas_seq #(
  parameter int CODE_W      = 10,
  parameter int RST_CYCLES  = 4,
  parameter int RAMP_CYCLES = 40,
  parameter int RAMPS_LOG2  = 7,
  parameter int RAIL_MARGIN = 32
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           start,
  input  logic [2:0]                                     range_sel,
  input  logic                                           smp_valid,
  input  logic [CODE_W-1:0]                              smp_code,
  output logic [2:0]                                     range_oh,
  output logic                                           int_rst,
  output logic                                           adc_clk,
  output logic                                           busy,
  output logic                                           range_err,
  output logic                                           res_valid,
  output logic signed [CODE_W+$clog2(RAMP_CYCLES+1):0]   res_slope,
  output logic [2:0]                                     res_range
);

  localparam int RS_W = CODE_W + 1 + $clog2(RAMP_CYCLES + 1);

  logic                   integ, integ_nx, ramp_done, last_ramp, clr;
  logic signed [RS_W-1:0] ramp_total;

  rmeas_ctrl #(
    .RST_CYCLES (RST_CYCLES),
    .RAMP_CYCLES(RAMP_CYCLES),
    .RAMPS_LOG2 (RAMPS_LOG2)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .range_sel(range_sel),
    .range_q  (range_oh),
    .range_err(range_err),
    .busy     (busy),
    .integ    (integ),
    .integ_nx (integ_nx),
    .ramp_done(ramp_done),
    .last_ramp(last_ramp),
    .clr      (clr)
  );

  rmeas_clkgate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .integ   (integ),
    .integ_nx(integ_nx),
    .adc_clk (adc_clk)
  );

  rmeas_slope #(
    .CODE_W     (CODE_W),
    .RAIL_MARGIN(RAIL_MARGIN),
    .RS_W       (RS_W)
  ) u_slope (
    .clk       (clk),
    .rst_n     (rst_n),
    .integ     (integ),
    .ramp_done (ramp_done),
    .smp_valid (smp_valid),
    .smp_code  (smp_code),
    .ramp_total(ramp_total)
  );

  rmeas_avg #(
    .RS_W      (RS_W),
    .RAMPS_LOG2(RAMPS_LOG2)
  ) u_avg (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .ramp_done (ramp_done),
    .last_ramp (last_ramp),
    .ramp_total(ramp_total),
    .range_in  (range_oh),
    .res_valid (res_valid),
    .res_slope (res_slope),
    .res_range (res_range)
  );

  assign int_rst = !integ;

  // R8
  result_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (!busy && int_rst && !$past(int_rst)));

endmodule

// File: tb/tb_rmeas_seq.sv
module tb_rmeas_seq;

  localparam int CLK_P  = 10;
  localparam int RSTC   = 4;
  localparam int RAMPC  = 40;
  localparam int NRAMPS = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] range_sel = 3'b000;
  logic smp_valid = 1'b0;
  logic [9:0] smp_code = '0;
  logic [2:0] range_oh;
  logic int_rst, adc_clk, busy, range_err, res_valid;
  logic signed [16:0] res_slope;
  logic [2:0] res_range;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  rmeas_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .range_sel(range_sel),
    .smp_valid(smp_valid), .smp_code(smp_code), .range_oh(range_oh),
    .int_rst(int_rst), .adc_clk(adc_clk), .busy(busy), .range_err(range_err),
    .res_valid(res_valid), .res_slope(res_slope), .res_range(res_range)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int clampc(input int v);
    if (v < 0) return 0;
    if (v > 1023) return 1023;
    return v;
  endfunction

  function automatic bit usable(input int c);
    return (c >= 32) && (c <= 991);
  endfunction

  function automatic int gen(input int mode, input int base, input int step, input int k);
    int nz;
    nz = int'($urandom_range(6)) - 3;
    case (mode)
      0: return clampc(base + step * k + nz);
      1: return clampc(700 + 25 * k + nz);
      2: return clampc(1000 - step * k + nz);
      3: return 500;
      default: return int'($urandom_range(31));
    endcase
  endfunction

  task automatic run_meas(input logic [2:0] rng, input int mode, input bit inject);
    longint acc_m = 0;
    longint rsum = 0;
    longint expv;
    int prev_m = 0;
    bit hp = 0;
    bit prev_ir = 1;
    int ilen = 0;
    int rlen = 0;
    int nr = 0;
    int base, step, c;
    bit got = 0;
    bit len_bad = 0, rst_bad = 0, clk_bad = 0, oh_bad = 0, busy_bad = 0;
    bit ir;
    @(negedge clk);
    range_sel = rng;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy", busy, 1);
    chk(range_oh == rng, "R2 range_oh", range_oh, rng);
    chk(range_err == 1'b0, "R2 range_err", range_err, 0);
    base = int'($urandom_range(150)) + 40;
    step = int'($urandom_range(19)) + 1;
    for (int it = 0; it < 20000; it++) begin
      if (it > 0) @(negedge clk);
      start = 1'b0;
      ir = int_rst;
      if (ir && !prev_ir) begin
        if (ilen != RAMPC) len_bad = 1;
        acc_m += rsum;
        nr++;
        rsum = 0; hp = 0; ilen = 0;
        base = int'($urandom_range(150)) + 40;
        step = int'($urandom_range(19)) + 1;
      end
      if (!ir && prev_ir) begin
        if (rlen != RSTC) rst_bad = 1;
        rlen = 0;
      end
      if (ir) rlen++;
      if (ir && adc_clk) clk_bad = 1;
      if (!ir && (adc_clk != ((ilen % 2) == 0))) clk_bad = 1;
      if (range_oh != rng) oh_bad = 1;
      if (res_valid) begin got = 1; break; end
      if (!busy) busy_bad = 1;
      if (inject && it == 150) begin
        start = 1'b1;
        range_sel = (rng == 3'b001) ? 3'b100 : 3'b001;
      end
      smp_valid = ($urandom_range(7) != 0);
      if (!ir) begin
        c = gen(mode, base, step, ilen);
        smp_code = 10'(c);
        if (smp_valid && usable(c)) begin
          if (hp) rsum += c - prev_m;
          prev_m = c;
          hp = 1;
        end
        ilen++;
      end else begin
        smp_code = 10'($urandom_range(1023));
      end
      prev_ir = ir;
    end
    smp_valid = 1'b0;
    expv = acc_m >>> 7;
    chk(got, "R8 res_valid seen", got, 1);
    chk(longint'(res_slope) == expv, "R8/R7/R6 res_slope", longint'(res_slope), expv);
    chk(res_range == rng, "R10 res_range", res_range, rng);
    chk(busy == 1'b0, "R8 busy low at result", busy, 0);
    chk(nr == NRAMPS, "R4 ramp count", nr, NRAMPS);
    chk(!len_bad, "R4 integration length", len_bad, 0);
    chk(!rst_bad, "R4 reset length", rst_bad, 0);
    chk(!clk_bad, "R5 adc_clk gating", clk_bad, 0);
    chk(!busy_bad, "R4 busy during measurement", busy_bad, 0);
    if (inject) chk(!oh_bad, "R9 start while busy", oh_bad, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_code = 10'($urandom_range(1023));
    end
    chk(res_valid == 1'b0, "R8 single pulse", res_valid, 0);
    chk(longint'(res_slope) == expv, "R10 res_slope hold", longint'(res_slope), expv);
    chk(int_rst && !adc_clk, "R5 idle gate", adc_clk, 0);
    smp_valid = 1'b0;
  endtask

  initial begin
    #(CLK_P * 190000);
    n_bad++;
    $display("FAIL watchdog R4: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(int_rst == 1'b1, "R1 int_rst", int_rst, 1);
    chk(adc_clk == 1'b0, "R1 adc_clk", adc_clk, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
    chk(range_err == 1'b0, "R1 range_err", range_err, 0);
    chk(range_oh == 3'b001, "R1 range_oh", range_oh, 1);
    rst_n = 1'b1;
    @(negedge clk);
    foreach (illegal_codes[i]) begin
      range_sel = illegal_codes[i];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(range_err == 1'b1, "R3 range_err", range_err, 1);
      chk(busy == 1'b0, "R3 stays idle", busy, 0);
      chk(int_rst == 1'b1 && adc_clk == 1'b0, "R3 no ramp", int_rst, 1);
      @(negedge clk);
      chk(busy == 1'b0, "R3 still idle", busy, 0);
    end
    run_meas(3'b001, 0, 1'b0);
    run_meas(3'b010, 1, 1'b1);
    run_meas(3'b100, 2, 1'b0);
    run_meas(3'b001, 3, 1'b0);
    run_meas(3'b010, 4, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  logic [2:0] illegal_codes [4] = '{3'b000, 3'b011, 3'b101, 3'b111};

endmodule